// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block is a synthesizable behavioural model of a serial EEPROM that speaks the common three-wire protocol: a chip select, a serial clock and a data input from the host, and one data output back to it. The model oversamples these pins with its own system clock. It finds the leading start bit, collects a two-bit opcode and an address, and then reads, writes, opens or closes the write lock, or erases the whole array. The storage is an internal register array whose capacity and word width (bytes or 16-bit words) are parameters.

It is meant to sit in a chip-level or board-level simulation, or in an emulation build, in place of a real part. A write and an erase-all start a busy period whose length is a parameter counted in system clocks, about 6 ms in hardware. While the period lasts the model shows its state on the data output.

Top module: `uwire_eeprom`

## Requirements
- R1: Serial clock rising edges are ignored while chip select is low. With chip select high, edges are ignored until one arrives with data in at 1, which is the start bit. Data out is 0 whenever chip select is low.
- R2: Out of reset the write lock is closed. While it is closed, a write or an erase-all changes no location and starts no busy period, so data out stays 0 until chip select is dropped.
- R3: After the start bit the model takes a 2-bit opcode and then an address, both MSB first. Opcode 01 is a write: the next word-width data bits, MSB first, are stored at that address when the lock is open.
- R4: Opcode 10 is a read. While chip select stays high and the clock keeps running, whole words keep shifting out from consecutive addresses. After the last location the address wraps to location 0.
- R5: On a read, data out is 0 (a dummy bit) right after the last address bit. Each later rising edge then drives the next data bit, MSB first.
- R6: A write or erase-all that is accepted starts a busy period of BUSY_CYCLES system clocks. During that period data out is 0. After it ends, data out is 1 while chip select is high.
- R7: Opcode 00 is a special command, decoded from the two top address bits. 11 opens the write lock, 00 closes it, and 10 is erase-all. The lock stays as set across later commands.
- R8: An erase-all that is accepted sets every location to all ones.
- R9: The address is log2(BYTES) bits wide in byte organisation (WORD16=0, 8-bit words). It is one bit less in 16-bit organisation (WORD16=1). BYTES is 128, 256 or 512.
- R10: After reset data out is 0 and every location reads as all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select from the host, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data into the model |
| dout | output | 1 | Serial data and ready/busy status out of the model |

## Verification
The bench goes after the read that runs past the last word. A model without wraparound returns the wrong data or stalls at that point. It checks the dummy bit ahead of the data, because a model that sends the MSB one edge early shifts every word by one bit. It sends writes and erase-alls with the lock closed and reads the array back, so a missing lock check shows up as corrupted data or as a ready bit that should never appear. It also clocks a 1 with chip select low and sends leading zeros, because a model that takes either as a start bit misdecodes the command that follows. The 16-bit and the byte organisations are both run, so a wrong address width shows up as a misaligned opcode.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_BUSY,
    ST_DONE,
    ST_HOLD
  } uw_state_e;

  localparam logic [1:0] OPC_READ    = 2'b10;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_SPECIAL = 2'b00;

  localparam logic [1:0] SPC_UNLOCK = 2'b11;
  localparam logic [1:0] SPC_LOCK   = 2'b00;
  localparam logic [1:0] SPC_ERASE  = 2'b10;

endpackage

// File: rtl/uwire_sync.sv
module uwire_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] pin_s
);

  logic [N-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign pin_s = stg_q[STAGES-1];

endmodule

// File: rtl/uwire_store.sv
module uwire_store #(
  parameter int W  = 16,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          erase,
  input  logic          unlocked,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (wr) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];

  // R2: the array only changes while the lock is open
  a_r2_write_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr || erase) |-> unlocked);

  // R3: a write strobe lands its data at its address
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> mem_q[$past(addr)] == $past(wdata));

  // R8: erase fills the ends of the array with ones
  a_r8_erase_fills: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (mem_q[0] == '1) && (mem_q[DEPTH-1] == '1));

endmodule

// File: rtl/uwire_ctrl.sv
module uwire_ctrl
  import uwire_pkg::*;
#(
  parameter int          W           = 16,
  parameter int          AW          = 6,
  parameter int unsigned BUSY_CYCLES = 300000,
  localparam int MAXB = (AW > W) ? AW : W,
  localparam int CW   = $clog2(MAXB),
  localparam int LW   = $clog2(W),
  localparam int BW   = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sk_s,
  input  logic          di_s,
  input  logic [W-1:0]  rdata,
  output logic          dout,
  output logic          wr,
  output logic          erase,
  output logic          unlocked,
  output logic [AW-1:0] addr,
  output logic [W-1:0]  wdata
);

  uw_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    opc_q, opc_d;
  logic [AW-1:0] addr_q, addr_d, a_n;
  logic [W-1:0]  sh_q, sh_d, w_n;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic          wen_q, wen_d;
  logic          do_q, do_d;
  logic          sk_d1;
  logic          rise;
  logic [LW-1:0] bit_idx;

  assign rise    = sk_s & ~sk_d1;
  assign a_n     = {addr_q[AW-2:0], di_s};
  assign w_n     = {sh_q[W-2:0], di_s};
  assign bit_idx = LW'(W - 1) - cnt_q[LW-1:0];

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    opc_d  = opc_q;
    addr_d = addr_q;
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    wen_d  = wen_q;
    do_d   = do_q;
    wr     = 1'b0;
    erase  = 1'b0;
    case (st_q)
      ST_BUSY: begin
        do_d = 1'b0;
        if (bcnt_q == '0) st_d = ST_DONE;
        else              bcnt_d = bcnt_q - 1'b1;
      end
      ST_DONE: begin
        do_d = cs_s;
        if (!cs_s) st_d = ST_IDLE;
      end
      default: begin
        if (!cs_s) begin
          st_d = ST_IDLE;
          do_d = 1'b0;
        end else if (rise) begin
          case (st_q)
            ST_IDLE: begin
              if (di_s) begin
                st_d  = ST_OPC;
                cnt_d = '0;
              end
            end
            ST_OPC: begin
              opc_d = {opc_q[0], di_s};
              if (cnt_q == CW'(1)) begin
                st_d  = ST_ADDR;
                cnt_d = '0;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
            ST_ADDR: begin
              addr_d = a_n;
              if (cnt_q == CW'(AW - 1)) begin
                cnt_d = '0;
                case (opc_q)
                  OPC_READ: begin
                    st_d = ST_RDATA;
                    do_d = 1'b0;
                  end
                  OPC_WRITE: st_d = ST_WDATA;
                  OPC_SPECIAL: begin
                    st_d = ST_HOLD;
                    case (a_n[AW-1:AW-2])
                      SPC_UNLOCK: wen_d = 1'b1;
                      SPC_LOCK:   wen_d = 1'b0;
                      SPC_ERASE: begin
                        if (wen_q) begin
                          erase  = 1'b1;
                          st_d   = ST_BUSY;
                          bcnt_d = BW'(BUSY_CYCLES - 1);
                        end
                      end
                      default: ;
                    endcase
                  end
                  default: st_d = ST_HOLD;
                endcase
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
            ST_RDATA: begin
              do_d = rdata[bit_idx];
              if (cnt_q == CW'(W - 1)) begin
                cnt_d  = '0;
                addr_d = addr_q + 1'b1;
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
            ST_WDATA: begin
              sh_d = w_n;
              if (cnt_q == CW'(W - 1)) begin
                cnt_d = '0;
                if (wen_q) begin
                  wr     = 1'b1;
                  st_d   = ST_BUSY;
                  bcnt_d = BW'(BUSY_CYCLES - 1);
                end else begin
                  st_d = ST_HOLD;
                end
              end else begin
                cnt_d = cnt_q + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      opc_q  <= '0;
      addr_q <= '0;
      sh_q   <= '0;
      bcnt_q <= '0;
      wen_q  <= 1'b0;
      do_q   <= 1'b0;
      sk_d1  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      opc_q  <= opc_d;
      addr_q <= addr_d;
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      wen_q  <= wen_d;
      do_q   <= do_d;
      sk_d1  <= sk_s;
    end
  end

  assign dout     = do_q;
  assign unlocked = wen_q;
  assign addr     = addr_q;
  assign wdata    = w_n;

  // R1: a deselected idle model keeps its output low
  a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && st_q != ST_BUSY && st_q != ST_DONE) |=> !dout);

  // R6: busy shows 0 on the output
  a_r6_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY) |=> !dout);

  // R6: no new store operation starts during a busy period
  a_r6_no_store_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY) |-> !(wr || erase));

  // R7: the lock only moves on a serial clock edge
  a_r7_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(wen_q));

endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int          BYTES       = 128,
  parameter bit          WORD16      = 1'b1,
  parameter int unsigned BUSY_CYCLES = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout
);

  localparam int W  = WORD16 ? 16 : 8;
  localparam int AW = WORD16 ? $clog2(BYTES) - 1 : $clog2(BYTES);

  logic [2:0]    pins_s;
  logic          wr, erase, unlocked;
  logic [AW-1:0] addr;
  logic [W-1:0]  wdata, rdata;

  uwire_sync #(.N(3), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({cs, sk, di}),
    .pin_s (pins_s)
  );

  uwire_ctrl #(.W(W), .AW(AW), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (pins_s[2]),
    .sk_s     (pins_s[1]),
    .di_s     (pins_s[0]),
    .rdata    (rdata),
    .dout     (dout),
    .wr       (wr),
    .erase    (erase),
    .unlocked (unlocked),
    .addr     (addr),
    .wdata    (wdata)
  );

  uwire_store #(.W(W), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr),
    .erase    (erase),
    .unlocked (unlocked),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata)
  );

endmodule

// File: tb/sim_uwire_eeprom.sv
module sim_uwire_eeprom;

  localparam int BUSY = 40;

  logic clk, rst_n, cs0, cs1, sk, di;
  wire  do0, do1;

  int n_run, n_fail, idle_cnt, idle_err, sel;
  int m0 [64];
  int m1 [256];
  bit wen0, wen1;

  uwire_eeprom #(.BYTES(128), .WORD16(1'b1), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs0), .sk(sk), .di(di), .dout(do0));

  uwire_eeprom #(.BYTES(256), .WORD16(1'b0), .BUSY_CYCLES(BUSY)) u1 (
    .clk(clk), .rst_n(rst_n), .cs(cs1), .sk(sk), .di(di), .dout(do1));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Per-clock reference: a deselected model must hold its output low (R1)
  always @(negedge clk) begin
    if (!rst_n || cs0 || cs1) idle_cnt <= 0;
    else begin
      idle_cnt <= idle_cnt + 1;
      if (idle_cnt >= 4 && (do0 || do1)) idle_err <= idle_err + 1;
    end
  end

  function automatic int aw_of();
    return sel ? 8 : 6;
  endfunction
  function automatic int w_of();
    return sel ? 8 : 16;
  endfunction
  function automatic logic cur_do();
    return sel ? do1 : do0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic d, output logic q);
    @(negedge clk); di = d; sk = 1'b0;
    repeat (4) @(negedge clk);
    sk = 1'b1;
    repeat (4) @(negedge clk);
    q = cur_do();
  endtask

  task automatic deselect();
    @(negedge clk); cs0 = 1'b0; cs1 = 1'b0; sk = 1'b0; di = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input int a, input int zeros,
                          output logic q);
    @(negedge clk);
    if (sel) cs1 = 1'b1; else cs0 = 1'b1;
    for (int i = 0; i < zeros; i++) sbit(1'b0, q);
    sbit(1'b1, q);
    sbit(op[1], q);
    sbit(op[0], q);
    for (int i = aw_of() - 1; i >= 0; i--) sbit(a[i], q);
  endtask

  task automatic rd(input int a, input int n, input string tag, input int zeros);
    logic q;
    int v, depth;
    depth = 1 << aw_of();
    send_cmd(2'b10, a, zeros, q);
    check({tag, " R5 dummy bit"}, q, 0);
    for (int k = 0; k < n; k++) begin
      v = 0;
      for (int b = 0; b < w_of(); b++) begin
        sbit(1'b0, q);
        v = (v << 1) | int'(q);
      end
      check(tag, v, sel ? m1[(a + k) % depth] : m0[(a + k) % depth]);
    end
    deselect();
  endtask

  task automatic busy_wait(input bit accepted, input string tag, input logic q);
    check({tag, " R6 busy/idle low"}, q, 0);
    repeat (BUSY + 10) @(negedge clk);
    check({tag, accepted ? " R6 ready high" : " R2 no ready"}, cur_do(), accepted ? 1 : 0);
  endtask

  task automatic wr(input int a, input int v, input string tag);
    logic q;
    bit en;
    en = sel ? wen1 : wen0;
    send_cmd(2'b01, a, 0, q);
    for (int b = w_of() - 1; b >= 0; b--) sbit(v[b], q);
    busy_wait(en, tag, q);
    if (en) begin
      if (sel) m1[a] = v; else m0[a] = v;
    end
    deselect();
  endtask

  task automatic special(input logic [1:0] top, input string tag);
    logic q;
    bit en;
    en = sel ? wen1 : wen0;
    send_cmd(2'b00, int'(top) << (aw_of() - 2), 0, q);
    if (top == 2'b10) begin
      busy_wait(en, tag, q);
      if (en) begin
        if (sel) for (int i = 0; i < 256; i++) m1[i] = 'hFF;
        else     for (int i = 0; i < 64; i++)  m0[i] = 'hFFFF;
      end
    end
    if (top == 2'b11) begin if (sel) wen1 = 1; else wen0 = 1; end
    if (top == 2'b00) begin if (sel) wen1 = 0; else wen0 = 0; end
    deselect();
  endtask

  initial begin
    logic q;
    n_run = 0; n_fail = 0; idle_cnt = 0; idle_err = 0; sel = 0;
    wen0 = 0; wen1 = 0;
    for (int i = 0; i < 64; i++)  m0[i] = 'hFFFF;
    for (int i = 0; i < 256; i++) m1[i] = 'hFF;
    cs0 = 0; cs1 = 0; sk = 0; di = 0; rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R10 reset dout u0", do0, 0);
    check("R10 reset dout u1", do1, 0);

    // R1: clocks with data 1 while deselected, then leading zeros
    for (int i = 0; i < 5; i++) sbit(1'b1, q);
    rd(3, 1, "R1 R10 read after ignored clocks", 3);

    // R2: write with lock closed at reset
    wr(5, 'h1234, "R2 locked write");
    rd(5, 1, "R2 locked write readback", 0);

    // R7 unlock, R3 write, R6 busy
    special(2'b11, "R7 unlock");
    wr(5, 'h1234, "R3 write");
    rd(5, 1, "R3 write readback", 0);

    // R4 sequential read across end of array
    wr(63, 'hBEEF, "R3 write top");
    wr(0, 'h0F0F, "R3 write bottom");
    wr(1, 'hA55A, "R3 write second");
    rd(62, 4, "R4 sequential wrap", 0);

    // R7 lock closes writes
    special(2'b00, "R7 lock");
    wr(7, 'h7777, "R7 write after lock");
    rd(7, 1, "R7 locked readback", 0);

    // R8 / R2 erase-all while locked is ignored
    special(2'b10, "R2 locked erase");
    rd(5, 1, "R2 locked erase readback", 0);
    special(2'b11, "R7 unlock again");
    special(2'b10, "R8 erase");
    rd(62, 4, "R8 erased readback", 0);
    special(2'b00, "R7 lock again");

    // R9 byte organisation, 8-bit address
    sel = 1;
    special(2'b11, "R9 unlock byte");
    wr('hA5, 'h3C, "R9 byte write");
    wr('hA6, 'hC3, "R9 byte write next");
    rd('hA5, 2, "R9 byte sequential", 0);
    rd('hFF, 2, "R9 R4 byte wrap", 0);
    sel = 0;

    check("R1 deselected output low every clock", idle_err, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule